// File: doc/BRIEF.md
# PCI Host Bridge Register Block

This block is the processor-facing register front end of an on-chip PCI host bridge. A 32-bit register bus reaches a 0x224-byte window that answers at either of two base addresses. The bottom 256 bytes of the window are the bridge's own configuration header, held in local storage. Above the header sit three control words: a configuration address, a memory base and an I/O base. A data port turns each processor access into one indirect configuration cycle on a downstream request interface, at the address held in the configuration address register.

Beside the register path, the block has two combinational side paths. The first translates a fixed 256 KB processor window into I/O-space addresses, using an offset taken from the I/O base register. The second routes each downstream device's interrupt onto one of four interrupt outputs, chosen by that device's slot number.

The register bus uses a single valid/ready handshake, and the response is presented in the handshake cycle. Once the master raises `req_valid`, it must hold every request field stable until it sees `req_ready` high at a clock edge. Only that edge commits a write. Register and error accesses complete in the cycle they are presented. Data-port accesses apply back-pressure until the downstream interface acknowledges.

Top module: `pcihb_top`

## Requirements
- R1: Only word accesses (`req_size` = 2) are honoured. Any other size completes in its first cycle with `rsp_err` = 1 and read data zero. It changes no register and raises no downstream request.
- R2: Window offsets 0x000 to 0x0FC hold 64 readable and writable 32-bit header words. Header byte 4k+j sits in bits 8j+7:8j of word k.
- R3: After reset, header word 1 reads 0x0290_0080 and every other header word reads zero. In word 1, command bit 7 is wait-cycle control; status bits 4, 7 and 9 are capability list, fast back-to-back and medium select timing.
- R4: Offset 0x1C0 (configuration address) stores the full written value and reads it back unchanged.
- R5: Offset 0x1C4 (memory base) stores the written value ANDed with 0xFF00_0001.
- R6: Offset 0x1C8 (I/O base) stores the written value ANDed with 0xFFFC_0001.
- R7: A word write to offset 0x220 issues one downstream write with the configuration address and the write data. A word read there returns `cfg_rdata` from a downstream read at the same address.
- R8: A data-port access keeps `req_ready` low until `cfg_ready` is high, and completes in that cycle. All other accesses complete in the cycle they are presented.
- R9: All other offsets read zero and ignore writes. This covers 0x100 to 0x1BC, 0x1CC to 0x21C, and addresses outside both windows.
- R10: The window answers identically at `REG_BASE_A` and `REG_BASE_B`.
- R11: `io_hit` is high exactly when `cpu_addr` lies in [`IO_WIN_BASE`, `IO_WIN_BASE` + 256 KB). When it is high, `io_addr` = (I/O base AND 0xFFFC_0000) + `cpu_addr`[17:0]; otherwise `io_addr` is zero.
- R12: `irq_out[s]` is the OR of every `dev_irq[d]` whose 2-bit slot field `dev_slot[2d+1:2d]` equals s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register access presented |
| req_ready | output | 1 | Access completes at this edge; response valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_addr | input | 32 | Processor byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| rsp_err | output | 1 | Error response, valid with req_ready |
| cfg_valid | output | 1 | Downstream configuration request |
| cfg_ready | input | 1 | Downstream acknowledge |
| cfg_write | output | 1 | Downstream request is a write |
| cfg_addr | output | 32 | Configuration address register value |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_rdata | input | 32 | Downstream read data, valid with cfg_ready |
| cpu_addr | input | 32 | Processor address for the I/O window |
| io_hit | output | 1 | cpu_addr is inside the I/O window |
| io_addr | output | 32 | Translated I/O-space address |
| dev_irq | input | NDEV | Device interrupt levels |
| dev_slot | input | 2*NDEV | Slot number of each device |
| irq_out | output | 4 | Routed interrupt lines |

## Verification
The bench builds the block with `NDEV` = 3 and keeps the defaults for the window bases. With three devices, every slot assignment can be swept against every interrupt pattern: 64 assignments times 8 levels. The 64-word header is small enough to be read at reset, written and read back in full, with the write going through one alias and the read through the other. The downstream target model answers after a fixed three-cycle delay, so the bench counts the exact number of back-pressure cycles. It checks this against the single-cycle completion of every other access.

// File: rtl/pcihb_pkg.sv
package pcihb_pkg;
  localparam int unsigned HDR_WORDS = 64;
  localparam int unsigned HDR_IDX_W = $clog2(HDR_WORDS);
  localparam logic [31:0] HDR_BYTES = 32'(HDR_WORDS * 4);
  localparam logic [31:0] WIN_BYTES = 32'h0000_0224;

  localparam logic [11:0] OFF_CADDR  = 12'h1C0;
  localparam logic [11:0] OFF_MBASE  = 12'h1C4;
  localparam logic [11:0] OFF_IOBASE = 12'h1C8;
  localparam logic [11:0] OFF_DPORT  = 12'h220;

  localparam logic [31:0] MBASE_MASK  = 32'hFF00_0001;
  localparam logic [31:0] IOBASE_MASK = 32'hFFFC_0001;
  localparam logic [31:0] IO_OFS_MASK = 32'hFFFC_0000;

  // command: wait-cycle control (bit 7); status: cap list, fast b2b, medium timing
  localparam logic [15:0] CMD_RST  = 16'h0080;
  localparam logic [15:0] STAT_RST = 16'h0290;
  localparam logic [31:0] HDR_W1_RST = {STAT_RST, CMD_RST};

  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [2:0] {
    RG_NONE, RG_HDR, RG_CADDR, RG_MBASE, RG_IOBASE, RG_DPORT
  } region_e;
endpackage

// File: rtl/pcihb_decode.sv
module pcihb_decode
  import pcihb_pkg::*;
#(
  parameter logic [31:0] BASE_A = 32'hFE20_0000,
  parameter logic [31:0] BASE_B = 32'h1E20_0000
) (
  input  logic [31:0]          addr,
  output region_e              region,
  output logic [HDR_IDX_W-1:0] hdr_idx
);
  localparam int unsigned NALIAS = 2;
  localparam logic [NALIAS-1:0][31:0] BASES = {BASE_B, BASE_A};

  logic [NALIAS-1:0][31:0] off_each;
  logic [NALIAS-1:0]       in_each;

  genvar g;
  generate
    for (g = 0; g < NALIAS; g++) begin : g_alias
      assign off_each[g] = addr - BASES[g];
      assign in_each[g]  = off_each[g] < WIN_BYTES;
    end
  endgenerate

  logic [31:0] off;
  logic [11:0] woff;

  always_comb begin
    off = in_each[0] ? off_each[0] : off_each[1];
    woff = {off[11:2], 2'b00};
    hdr_idx = off[HDR_IDX_W+1:2];
    region = RG_NONE;
    if (|in_each) begin
      if (off < HDR_BYTES) region = RG_HDR;
      else begin
        unique case (woff)
          OFF_CADDR:  region = RG_CADDR;
          OFF_MBASE:  region = RG_MBASE;
          OFF_IOBASE: region = RG_IOBASE;
          OFF_DPORT:  region = RG_DPORT;
          default:    region = RG_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcihb_regfile.sv
module pcihb_regfile
  import pcihb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  region_e              region,
  input  logic [HDR_IDX_W-1:0] hdr_idx,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [31:0]          caddr_q,
  output logic [31:0]          iobase_q
);
  logic [31:0] hdr_q [HDR_WORDS];
  logic [31:0] mbase_q;

  genvar g;
  generate
    for (g = 0; g < HDR_WORDS; g++) begin : g_hdr
      localparam logic [31:0] RST_VAL = (g == 1) ? HDR_W1_RST : 32'h0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hdr_q[g] <= RST_VAL;
        else if (wr_en && region == RG_HDR && hdr_idx == HDR_IDX_W'(g))
          hdr_q[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q  <= '0;
      mbase_q  <= '0;
      iobase_q <= '0;
    end else if (wr_en) begin
      case (region)
        RG_CADDR:  caddr_q  <= wdata;
        RG_MBASE:  mbase_q  <= wdata & MBASE_MASK;
        RG_IOBASE: iobase_q <= wdata & IOBASE_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (region)
      RG_HDR:    rdata = hdr_q[hdr_idx];
      RG_CADDR:  rdata = caddr_q;
      RG_MBASE:  rdata = mbase_q;
      RG_IOBASE: rdata = iobase_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/pcihb_iowin.sv
module pcihb_iowin
  import pcihb_pkg::*;
#(
  parameter logic [31:0] WIN_BASE  = 32'hFE24_0000,
  parameter int unsigned SPAN_BITS = 18
) (
  input  logic [31:0] cpu_addr,
  input  logic [31:0] iobase,
  output logic        io_hit,
  output logic [31:0] io_addr
);
  localparam logic [31:0] LOCAL_MASK = (32'h1 << SPAN_BITS) - 32'h1;

  always_comb begin
    io_hit  = (cpu_addr & ~LOCAL_MASK) == (WIN_BASE & ~LOCAL_MASK);
    io_addr = io_hit ? (iobase & IO_OFS_MASK) + (cpu_addr & LOCAL_MASK) : 32'h0;
  end
endmodule

// File: rtl/pcihb_irqroute.sv
module pcihb_irqroute #(
  parameter int unsigned NDEV   = 4,
  parameter int unsigned NLINES = 4,
  localparam int unsigned SLOT_W = $clog2(NLINES)
) (
  input  logic [NDEV-1:0]        dev_irq,
  input  logic [NDEV*SLOT_W-1:0] dev_slot,
  output logic [NLINES-1:0]      irq_out
);
  genvar s;
  generate
    for (s = 0; s < NLINES; s++) begin : g_line
      always_comb begin
        irq_out[s] = 1'b0;
        for (int d = 0; d < NDEV; d++)
          if (dev_slot[d*SLOT_W +: SLOT_W] == SLOT_W'(s))
            irq_out[s] = irq_out[s] | dev_irq[d];
      end
    end
  endgenerate
endmodule

// File: rtl/pcihb_top.sv
module pcihb_top
  import pcihb_pkg::*;
#(
  parameter logic [31:0] REG_BASE_A   = 32'hFE20_0000,
  parameter logic [31:0] REG_BASE_B   = 32'h1E20_0000,
  parameter logic [31:0] IO_WIN_BASE  = 32'hFE24_0000,
  parameter int unsigned IO_SPAN_BITS = 18,
  parameter int unsigned NDEV         = 4,
  localparam int unsigned NLINES = 4,
  localparam int unsigned SLOT_W = $clog2(NLINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [31:0]            req_addr,
  input  logic [31:0]            req_wdata,
  output logic [31:0]            rsp_rdata,
  output logic                   rsp_err,
  output logic                   cfg_valid,
  input  logic                   cfg_ready,
  output logic                   cfg_write,
  output logic [31:0]            cfg_addr,
  output logic [31:0]            cfg_wdata,
  input  logic [31:0]            cfg_rdata,
  input  logic [31:0]            cpu_addr,
  output logic                   io_hit,
  output logic [31:0]            io_addr,
  input  logic [NDEV-1:0]        dev_irq,
  input  logic [NDEV*SLOT_W-1:0] dev_slot,
  output logic [NLINES-1:0]      irq_out
);
  region_e              region;
  logic [HDR_IDX_W-1:0] hdr_idx;
  logic [31:0]          reg_rdata;
  logic [31:0]          iobase_q;
  logic                 size_err;
  logic                 is_dport;
  logic                 wr_en;

  pcihb_decode #(.BASE_A(REG_BASE_A), .BASE_B(REG_BASE_B)) u_dec (
    .addr(req_addr), .region(region), .hdr_idx(hdr_idx)
  );

  always_comb begin
    size_err  = req_valid && (req_size != SZ_WORD);
    is_dport  = region == RG_DPORT;
    cfg_valid = req_valid && !size_err && is_dport;
    cfg_write = req_write;
    cfg_wdata = req_wdata;
    req_ready = req_valid && (size_err || !is_dport || cfg_ready);
    rsp_err   = size_err;
    if (size_err)      rsp_rdata = '0;
    else if (is_dport) rsp_rdata = cfg_rdata;
    else               rsp_rdata = reg_rdata;
    wr_en = req_valid && req_ready && req_write && !size_err;
  end

  pcihb_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .region(region),
    .hdr_idx(hdr_idx), .wdata(req_wdata), .rdata(reg_rdata),
    .caddr_q(cfg_addr), .iobase_q(iobase_q)
  );

  pcihb_iowin #(.WIN_BASE(IO_WIN_BASE), .SPAN_BITS(IO_SPAN_BITS)) u_io (
    .cpu_addr(cpu_addr), .iobase(iobase_q), .io_hit(io_hit), .io_addr(io_addr)
  );

  pcihb_irqroute #(.NDEV(NDEV), .NLINES(NLINES)) u_irq (
    .dev_irq(dev_irq), .dev_slot(dev_slot), .irq_out(irq_out)
  );
endmodule

// File: rtl/pcihb_chk.sv
module pcihb_chk #(
  parameter int unsigned SPAN_BITS = 18,
  parameter int unsigned NLINES    = 4,
  parameter int unsigned NDEV      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_size,
  input logic              rsp_err,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [31:0]       cfg_addr,
  input logic [31:0]       cpu_addr,
  input logic              io_hit,
  input logic [31:0]       io_addr,
  input logic [NDEV-1:0]   dev_irq,
  input logic [NLINES-1:0] irq_out
);
  p_err_no_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd2) |-> (!cfg_valid && req_ready));

  p_err_keeps_caddr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rsp_err) |=> $stable(cfg_addr));

  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |-> !req_ready);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready) |-> (req_ready && !rsp_err));

  p_io_low_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (io_addr[SPAN_BITS-1:0] == cpu_addr[SPAN_BITS-1:0]));

  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq == '0) |-> (irq_out == '0));

  p_irq_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq_out) <= $countones(dev_irq)));
endmodule

bind pcihb_top pcihb_chk #(.SPAN_BITS(IO_SPAN_BITS), .NLINES(NLINES), .NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .rsp_err(rsp_err), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cpu_addr(cpu_addr),
  .io_hit(io_hit), .io_addr(io_addr), .dev_irq(dev_irq), .irq_out(irq_out)
);

// File: tb/sim_pcihb_top.sv
`timescale 1ns/1ps
module sim_pcihb_top;
  localparam int NDEV = 3;
  localparam int LAT = 3;
  localparam logic [31:0] BA = 32'hFE20_0000;
  localparam logic [31:0] BB = 32'h1E20_0000;
  localparam logic [31:0] IOB = 32'hFE24_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, rsp_err;
  logic [1:0] req_size;
  logic [31:0] req_addr, req_wdata, rsp_rdata;
  logic cfg_valid, cfg_ready, cfg_write;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata, cpu_addr, io_addr;
  logic io_hit;
  logic [NDEV-1:0] dev_irq;
  logic [2*NDEV-1:0] dev_slot;
  logic [3:0] irq_out;

  pcihb_top #(.NDEV(NDEV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_addr(cpu_addr), .io_hit(io_hit), .io_addr(io_addr),
    .dev_irq(dev_irq), .dev_slot(dev_slot), .irq_out(irq_out)
  );

  int checks = 0;
  int errors = 0;

  // downstream target model: fixed latency, 16-word store
  logic [31:0] tmem [16];
  int cnt = 0;
  initial begin
    for (int i = 0; i < 16; i++) tmem[i] = 32'h0;
    cfg_ready = 1'b0;
  end
  assign cfg_rdata = tmem[cfg_addr[5:2]];
  always @(posedge clk) begin
    if (cfg_valid && cfg_ready) begin
      cnt <= 0;
      if (cfg_write) tmem[cfg_addr[5:2]] <= cfg_wdata;
    end else if (cfg_valid) cnt <= cnt + 1;
    else cnt <= 0;
  end
  always @(negedge clk) cfg_ready = (cnt == LAT);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic w,
                     input logic [31:0] wd, output logic [31:0] rd,
                     output logic er, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = w; req_wdata = wd;
    cyc = 1;
    #2;
    while (!req_ready) begin
      @(negedge clk); #2; cyc++;
    end
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'h0101_0101 * i) ^ 32'h8C3E_51A7;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic er;
    int cyc;
    logic [31:0] vals [4];
    logic [31:0] last_mb, last_io;
    vals[0] = 32'hFFFF_FFFF; vals[1] = 32'h1234_5678;
    vals[2] = 32'h00FF_FFFE; vals[3] = 32'h8107_C3A5;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
    req_addr = '0; req_wdata = '0; cpu_addr = '0; dev_irq = '0; dev_slot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: header reset contents
    for (int i = 0; i < 64; i++) begin
      acc(BA + 32'(4*i), 2'd2, 1'b0, '0, rd, er, cyc);
      chk("R3 header reset", rd, (i == 1) ? 32'h0290_0080 : 32'h0);
    end
    // R2, R10: write via one alias, read via the other
    for (int i = 0; i < 64; i++) acc(BA + 32'(4*i), 2'd2, 1'b1, pat(i), rd, er, cyc);
    for (int i = 0; i < 64; i++) begin
      acc(BB + 32'(4*i), 2'd2, 1'b0, '0, rd, er, cyc);
      chk("R2 R10 header readback", rd, pat(i));
    end
    // R4, R8 single-cycle completion
    acc(BB + 32'h1C0, 2'd2, 1'b1, 32'hFFFF_FFFF, rd, er, cyc);
    chk("R8 register write cycles", 32'(cyc), 32'd1);
    acc(BA + 32'h1C0, 2'd2, 1'b0, '0, rd, er, cyc);
    chk("R4 caddr full value", rd, 32'hFFFF_FFFF);
    chk("R8 register read cycles", 32'(cyc), 32'd1);
    acc(BA + 32'h1C0, 2'd2, 1'b1, 32'h0000_0014, rd, er, cyc);
    acc(BB + 32'h1C0, 2'd2, 1'b0, '0, rd, er, cyc);
    chk("R4 R10 caddr", rd, 32'h0000_0014);
    // R5 memory base mask
    for (int k = 0; k < 4; k++) begin
      acc(BA + 32'h1C4, 2'd2, 1'b1, vals[k], rd, er, cyc);
      acc(BB + 32'h1C4, 2'd2, 1'b0, '0, rd, er, cyc);
      chk("R5 mbase mask", rd, vals[k] & 32'hFF00_0001);
    end
    last_mb = vals[3] & 32'hFF00_0001;
    // R6 I/O base mask, R11 window translation
    for (int k = 0; k < 4; k++) begin
      acc(BB + 32'h1C8, 2'd2, 1'b1, vals[k], rd, er, cyc);
      acc(BA + 32'h1C8, 2'd2, 1'b0, '0, rd, er, cyc);
      chk("R6 iobase mask", rd, vals[k] & 32'hFFFC_0001);
      for (int j = 0; j < 5; j++) begin
        logic [31:0] ca;
        logic inwin;
        case (j)
          0: ca = IOB;
          1: ca = IOB + 32'h3FFFC;
          2: ca = IOB + 32'h12344;
          3: ca = IOB - 32'h4;
          default: ca = IOB + 32'h40000;
        endcase
        inwin = (ca >= IOB) && (ca < IOB + 32'h40000);
        @(negedge clk); cpu_addr = ca; #1;
        chk("R11 io_hit", {31'b0, io_hit}, {31'b0, inwin});
        chk("R11 io_addr", io_addr,
            inwin ? (vals[k] & 32'hFFFC_0000) + (ca - IOB) : 32'h0);
      end
    end
    last_io = vals[3] & 32'hFFFC_0001;
    // R7, R8: data port
    acc(BA + 32'h220, 2'd2, 1'b1, 32'hCAFE_F00D, rd, er, cyc);
    chk("R7 dport write target", tmem[5], 32'hCAFE_F00D);
    chk("R8 dport write cycles", 32'(cyc), LAT + 1);
    acc(BA + 32'h1C0, 2'd2, 1'b1, 32'h0000_0024, rd, er, cyc);
    acc(BB + 32'h220, 2'd2, 1'b1, 32'h0BAD_1DEA, rd, er, cyc);
    chk("R7 dport write second addr", tmem[9], 32'h0BAD_1DEA);
    chk("R7 first word untouched", tmem[5], 32'hCAFE_F00D);
    acc(BA + 32'h220, 2'd2, 1'b0, '0, rd, er, cyc);
    chk("R7 dport read", rd, 32'h0BAD_1DEA);
    chk("R8 dport read cycles", 32'(cyc), LAT + 1);
    acc(BA + 32'h1C0, 2'd2, 1'b1, 32'h0000_0014, rd, er, cyc);
    acc(BB + 32'h220, 2'd2, 1'b0, '0, rd, er, cyc);
    chk("R7 dport read first", rd, 32'hCAFE_F00D);
    // R1: non-word sizes
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      acc(BA + 32'h1C0, 2'(s), 1'b1, 32'hDEAD_0000, rd, er, cyc);
      chk("R1 err flag", {31'b0, er}, 32'h1);
      chk("R1 err cycles", 32'(cyc), 32'd1);
      acc(BA + 32'h00C, 2'(s), 1'b1, 32'h5555_AAAA, rd, er, cyc);
      acc(BA + 32'h220, 2'(s), 1'b1, 32'h7777_7777, rd, er, cyc);
      chk("R1 dport err cycles", 32'(cyc), 32'd1);
      chk("R1 no downstream write", tmem[5], 32'hCAFE_F00D);
      acc(BA + 32'h1C0, 2'(s), 1'b0, '0, rd, er, cyc);
      chk("R1 err read data", rd, 32'h0);
      acc(BA + 32'h1C0, 2'd2, 1'b0, '0, rd, er, cyc);
      chk("R1 caddr unchanged", rd, 32'h0000_0014);
      acc(BB + 32'h00C, 2'd2, 1'b0, '0, rd, er, cyc);
      chk("R1 header unchanged", rd, pat(3));
    end
    // R9: unmapped offsets
    for (int j = 0; j < 7; j++) begin
      logic [31:0] a;
      case (j)
        0: a = BA + 32'h100;
        1: a = BB + 32'h1BC;
        2: a = BA + 32'h1CC;
        3: a = BB + 32'h21C;
        4: a = BA + 32'h224;
        5: a = BB - 32'h4;
        default: a = BA + 32'h1000;
      endcase
      acc(a, 2'd2, 1'b1, 32'hFFFF_FFFF, rd, er, cyc);
      acc(a, 2'd2, 1'b0, '0, rd, er, cyc);
      chk("R9 unmapped reads zero", rd, 32'h0);
    end
    acc(BA + 32'h1C0, 2'd2, 1'b0, '0, rd, er, cyc);
    chk("R9 caddr kept", rd, 32'h0000_0014);
    acc(BA + 32'h1C4, 2'd2, 1'b0, '0, rd, er, cyc);
    chk("R9 mbase kept", rd, last_mb);
    acc(BA + 32'h1C8, 2'd2, 1'b0, '0, rd, er, cyc);
    chk("R9 iobase kept", rd, last_io);
    acc(BA + 32'h000, 2'd2, 1'b0, '0, rd, er, cyc);
    chk("R9 header word 0 kept", rd, pat(0));
    acc(BA + 32'h0FC, 2'd2, 1'b0, '0, rd, er, cyc);
    chk("R9 header word 63 kept", rd, pat(63));
    // R12: exhaustive routing sweep
    for (int sl = 0; sl < 64; sl++) begin
      for (int lv = 0; lv < 8; lv++) begin
        logic [3:0] exp;
        exp = '0;
        for (int d = 0; d < NDEV; d++)
          if (lv[d]) exp[(sl >> (2*d)) & 3] = 1'b1;
        @(negedge clk); dev_slot = 6'(sl); dev_irq = 3'(lv); #1;
        chk("R12 irq routing", {28'b0, irq_out}, {28'b0, exp});
      end
    end
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule